// File: doc/BRIEF.md
# Receive Packet Buffer with Skip and Flush

This block sits between a frame receiver and a host port. Incoming frames arrive one 32-bit word per beat. The words go into a data queue. When the final word of a frame is accepted, a status word that carries the frame's length in words goes into a separate status queue. The host drains the two queues independently. It pops data words from one port and status words from another, and each port shows its head entry ahead of the pop.

Two host operations are provided, each started by a one-cycle request. A skip request throws away whatever is left of the packet at the head of the data queue. It does this by jumping the data read pointer to the start of the next packet. The receiver may keep writing while the jump happens, and the status queue is left as it is. A flush request, accepted only while the receiver reports it is halted, returns every pointer of both queues to its reset position. Each operation shows a busy flag that drops by itself when the work is finished.

The skip distance comes from the length of the packet at the head of the data queue, minus the words the host has already popped from that packet. That length is tracked through a second read pointer into the status storage. A status slot is reused only after the host has popped its status word and the data side has moved past its packet.

Top module: `rx_pkt_buffer`

## Requirements
- R1: After reset both used counts are zero, both valid flags and both busy flags are low, `ffwd_err` is low and `rx_ready` is high.
- R2: Each accepted word with `rx_valid && rx_ready` raises `data_used` by one one cycle later. Accepting the word with `rx_last` high adds one status entry whose bits [15:0] hold the packet length in words and whose bits [31:16] are zero.
- R3: Host data pops return words in arrival order, and each accepted pop lowers `data_used` by one. Status pops return status words in arrival order.
- R4: At a packet boundary, `rx_ready` is low when fewer than MAX_PKT_WORDS data words are free. It is also low when status storage is full, counting a slot as busy until its status has been popped and its packet's data has been consumed.
- R5: An accepted skip request sets `ffwd_busy` for exactly two cycles. When it falls, the data head is the first word of the next packet.
- R6: The skip removes only the words of the head packet not yet popped: `data_used` drops by the head length minus the words already read.
- R7: A skip request with no complete packet at the head, or with a head packet shorter than 4 words, pulses `ffwd_err` for one cycle, leaves `ffwd_busy` low and changes nothing in the queues.
- R8: While `ffwd_busy` is high, `host_data_rvalid` is low and data pops are ignored. A data pop in the same cycle as `ffwd_req` is also ignored. Status pops are still served.
- R9: A skip never removes a status entry. The skipped packet's status stays in the status queue until the host pops it.
- R10: Receiver words written during a skip are kept, and they form the packets that follow the skipped one.
- R11: A flush request with `rx_halted` high sets `dump_busy` for one cycle. After that cycle both queues are empty and `dump_busy` is low.
- R12: A flush request while `rx_halted` is low is ignored: `dump_busy` stays low and neither queue changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receiver word valid |
| rx_ready | output | 1 | Buffer can take the receiver word |
| rx_data | input | 32 | Receiver data word |
| rx_last | input | 1 | Word is the last of its packet |
| rx_halted | input | 1 | Receiver reports it is stopped |
| host_data_pop | input | 1 | Pop the head data word |
| host_data_rdata | output | 32 | Head data word |
| host_data_rvalid | output | 1 | Head data word may be popped |
| host_stat_pop | input | 1 | Pop the head status word |
| host_stat_rdata | output | 32 | Head status word |
| host_stat_rvalid | output | 1 | Head status word may be popped |
| ffwd_req | input | 1 | Request a skip of the head packet |
| ffwd_busy | output | 1 | Skip in progress, self-clearing |
| ffwd_err | output | 1 | One-cycle pulse: skip request refused |
| dump_req | input | 1 | Request a flush of both queues |
| dump_busy | output | 1 | Flush in progress, self-clearing |
| data_used | output | $clog2(DATA_DEPTH)+1 | Words held in the data queue |
| stat_used | output | $clog2(STAT_DEPTH)+1 | Status words the host can still pop |

## Verification
A wrong words-read count or a wrong head-length pointer shows up at the end of a skip. When `ffwd_busy` falls, `host_data_rdata` is not the next packet's first word and `data_used` is off by the error, so the mistake is visible two cycles after the request. Bad slot accounting appears as `rx_ready` staying low, or going high too early, right after the pop that should free a slot. A flush that misses a pointer leaves a nonzero used count on the cycle after `dump_busy`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int WORD_W         = 32;
    localparam int LEN_W          = 16;
    localparam int FFWD_MIN_WORDS = 4;

    typedef enum logic [1:0] {
        FF_IDLE = 2'd0,
        FF_CALC = 2'd1,
        FF_JUMP = 2'd2
    } ffwd_state_e;

    typedef struct packed {
        logic [WORD_W-LEN_W-1:0] rsvd;
        logic [LEN_W-1:0]        len;
    } stat_word_t;

    function automatic stat_word_t make_stat(input logic [LEN_W-1:0] len);
        stat_word_t s;
        s.rsvd = '0;
        s.len  = len;
        return s;
    endfunction
endpackage

// File: rtl/rxq_data_fifo.sv
module rxq_data_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       pop,
    input  logic                       skip_en,
    input  logic [$clog2(DEPTH):0]     skip_len,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH):0]     used
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en)
                wr_ptr <= wr_ptr + 1'b1;
            if (skip_en)
                rd_ptr <= rd_ptr + skip_len;
            else if (pop)
                rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_ptr[AW-1:0]] <= wr_data;
    end

    assign rdata = mem[rd_ptr[AW-1:0]];
    assign used  = wr_ptr - rd_ptr;
endmodule

// File: rtl/rxq_stat_fifo.sv
module rxq_stat_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic                   push,
    input  stat_word_t             wdata,
    input  logic                   host_pop,
    input  logic                   pkt_adv,
    output logic [WORD_W-1:0]      host_rdata,
    output logic [LEN_W-1:0]       head_len,
    output logic [$clog2(DEPTH):0] host_used,
    output logic [$clog2(DEPTH):0] pkt_used,
    output logic [$clog2(DEPTH):0] slot_used
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    stat_word_t    mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] host_ptr;
    logic [PW-1:0] pkt_ptr;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr   <= '0;
            host_ptr <= '0;
            pkt_ptr  <= '0;
        end else begin
            if (push)
                wr_ptr <= wr_ptr + 1'b1;
            if (host_pop)
                host_ptr <= host_ptr + 1'b1;
            if (pkt_adv)
                pkt_ptr <= pkt_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr[AW-1:0]] <= wdata;
    end

    assign host_rdata = mem[host_ptr[AW-1:0]];
    assign head_len   = mem[pkt_ptr[AW-1:0]].len;
    assign host_used  = wr_ptr - host_ptr;
    assign pkt_used   = wr_ptr - pkt_ptr;
    assign slot_used  = (host_used > pkt_used) ? host_used : pkt_used;
endmodule

// File: rtl/rxq_wr_ctrl.sv
module rxq_wr_ctrl
    import rxq_pkg::*;
#(
    parameter int DATA_DEPTH    = 32,
    parameter int STAT_DEPTH    = 8,
    parameter int MAX_PKT_WORDS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic                        rx_valid,
    input  logic                        rx_last,
    input  logic [$clog2(DATA_DEPTH):0] data_used,
    input  logic [$clog2(STAT_DEPTH):0] slot_used,
    output logic                        rx_ready,
    output logic                        data_wr,
    output logic                        stat_push,
    output stat_word_t                  stat_wdata
);
    localparam int DPW = $clog2(DATA_DEPTH) + 1;
    localparam int SPW = $clog2(STAT_DEPTH) + 1;

    logic             in_pkt;
    logic [LEN_W-1:0] wr_len;
    logic [DPW-1:0]   data_free;
    logic             room_new;
    logic             accept;

    assign data_free = DPW'(DATA_DEPTH) - data_used;
    assign room_new  = (data_free >= DPW'(MAX_PKT_WORDS)) &&
                       (slot_used < SPW'(STAT_DEPTH));
    assign rx_ready  = !flush && (in_pkt ? (data_used < DPW'(DATA_DEPTH)) : room_new);
    assign accept    = rx_valid && rx_ready;
    assign data_wr   = accept;
    assign stat_push = accept && rx_last;
    assign stat_wdata = make_stat(wr_len + 1'b1);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            in_pkt <= 1'b0;
            wr_len <= '0;
        end else if (accept) begin
            if (rx_last) begin
                in_pkt <= 1'b0;
                wr_len <= '0;
            end else begin
                in_pkt <= 1'b1;
                wr_len <= wr_len + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxq_rd_ctrl.sv
module rxq_rd_ctrl
    import rxq_pkg::*;
#(
    parameter int DATA_DEPTH = 32,
    parameter int STAT_DEPTH = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rx_halted,
    input  logic                        dump_req,
    input  logic                        ffwd_req,
    input  logic                        host_data_pop,
    input  logic                        host_stat_pop,
    input  logic [$clog2(DATA_DEPTH):0] data_used,
    input  logic [$clog2(STAT_DEPTH):0] host_used,
    input  logic [$clog2(STAT_DEPTH):0] pkt_used,
    input  logic [LEN_W-1:0]            head_len,
    output logic                        flush,
    output logic                        data_pop_ok,
    output logic                        stat_pop_ok,
    output logic                        data_rvalid,
    output logic                        stat_rvalid,
    output logic                        pkt_adv,
    output logic                        skip_en,
    output logic [$clog2(DATA_DEPTH):0] skip_len,
    output logic                        ffwd_busy,
    output logic                        ffwd_err,
    output logic                        dump_busy
);
    localparam int DPW = $clog2(DATA_DEPTH) + 1;

    ffwd_state_e      state;
    logic [LEN_W-1:0] words_read;
    logic             pop_done;
    logic             head_ok;

    assign flush       = dump_busy;
    assign ffwd_busy   = (state != FF_IDLE);
    assign data_rvalid = (data_used != '0) && !ffwd_busy && !dump_busy;
    assign stat_rvalid = (host_used != '0) && !dump_busy;
    assign data_pop_ok = host_data_pop && data_rvalid && !ffwd_req;
    assign stat_pop_ok = host_stat_pop && stat_rvalid;
    assign pop_done    = data_pop_ok && (pkt_used != '0) &&
                         (LEN_W'(words_read + 1'b1) == head_len);
    assign skip_en     = (state == FF_JUMP);
    assign pkt_adv     = pop_done || skip_en;
    assign head_ok     = (pkt_used != '0) && (head_len >= LEN_W'(FFWD_MIN_WORDS));

    always_ff @(posedge clk) begin
        if (rst)
            dump_busy <= 1'b0;
        else if (dump_busy)
            dump_busy <= 1'b0;
        else if (dump_req && rx_halted)
            dump_busy <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state      <= FF_IDLE;
            words_read <= '0;
            skip_len   <= '0;
            ffwd_err   <= 1'b0;
        end else begin
            ffwd_err <= 1'b0;
            unique case (state)
                FF_IDLE: begin
                    if (ffwd_req) begin
                        if (head_ok)
                            state <= FF_CALC;
                        else
                            ffwd_err <= 1'b1;
                    end
                    if (pop_done)
                        words_read <= '0;
                    else if (data_pop_ok)
                        words_read <= words_read + 1'b1;
                end
                FF_CALC: begin
                    skip_len <= DPW'(head_len - words_read);
                    state    <= FF_JUMP;
                end
                FF_JUMP: begin
                    words_read <= '0;
                    state      <= FF_IDLE;
                end
                default: state <= FF_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_pkt_buffer.sv
module rx_pkt_buffer
    import rxq_pkg::*;
#(
    parameter int DATA_DEPTH    = 32,
    parameter int STAT_DEPTH    = 8,
    parameter int MAX_PKT_WORDS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rx_valid,
    output logic                        rx_ready,
    input  logic [31:0]                 rx_data,
    input  logic                        rx_last,
    input  logic                        rx_halted,
    input  logic                        host_data_pop,
    output logic [31:0]                 host_data_rdata,
    output logic                        host_data_rvalid,
    input  logic                        host_stat_pop,
    output logic [31:0]                 host_stat_rdata,
    output logic                        host_stat_rvalid,
    input  logic                        ffwd_req,
    output logic                        ffwd_busy,
    output logic                        ffwd_err,
    input  logic                        dump_req,
    output logic                        dump_busy,
    output logic [$clog2(DATA_DEPTH):0] data_used,
    output logic [$clog2(STAT_DEPTH):0] stat_used
);
    localparam int DPW = $clog2(DATA_DEPTH) + 1;
    localparam int SPW = $clog2(STAT_DEPTH) + 1;

    logic             flush;
    logic             data_wr;
    logic             stat_push;
    stat_word_t       stat_wdata;
    logic             data_pop_ok;
    logic             stat_pop_ok;
    logic             pkt_adv;
    logic             skip_en;
    logic [DPW-1:0]   skip_len;
    logic [LEN_W-1:0] head_len;
    logic [SPW-1:0]   pkt_used;
    logic [SPW-1:0]   slot_used;

    rxq_data_fifo #(.DEPTH(DATA_DEPTH), .W(WORD_W)) u_data (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_en    (data_wr),
        .wr_data  (rx_data),
        .pop      (data_pop_ok),
        .skip_en  (skip_en),
        .skip_len (skip_len),
        .rdata    (host_data_rdata),
        .used     (data_used)
    );

    rxq_stat_fifo #(.DEPTH(STAT_DEPTH)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .push       (stat_push),
        .wdata      (stat_wdata),
        .host_pop   (stat_pop_ok),
        .pkt_adv    (pkt_adv),
        .host_rdata (host_stat_rdata),
        .head_len   (head_len),
        .host_used  (stat_used),
        .pkt_used   (pkt_used),
        .slot_used  (slot_used)
    );

    rxq_wr_ctrl #(
        .DATA_DEPTH    (DATA_DEPTH),
        .STAT_DEPTH    (STAT_DEPTH),
        .MAX_PKT_WORDS (MAX_PKT_WORDS)
    ) u_wr (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .rx_valid   (rx_valid),
        .rx_last    (rx_last),
        .data_used  (data_used),
        .slot_used  (slot_used),
        .rx_ready   (rx_ready),
        .data_wr    (data_wr),
        .stat_push  (stat_push),
        .stat_wdata (stat_wdata)
    );

    rxq_rd_ctrl #(.DATA_DEPTH(DATA_DEPTH), .STAT_DEPTH(STAT_DEPTH)) u_rd (
        .clk           (clk),
        .rst           (rst),
        .rx_halted     (rx_halted),
        .dump_req      (dump_req),
        .ffwd_req      (ffwd_req),
        .host_data_pop (host_data_pop),
        .host_stat_pop (host_stat_pop),
        .data_used     (data_used),
        .host_used     (stat_used),
        .pkt_used      (pkt_used),
        .head_len      (head_len),
        .flush         (flush),
        .data_pop_ok   (data_pop_ok),
        .stat_pop_ok   (stat_pop_ok),
        .data_rvalid   (host_data_rvalid),
        .stat_rvalid   (host_stat_rvalid),
        .pkt_adv       (pkt_adv),
        .skip_en       (skip_en),
        .skip_len      (skip_len),
        .ffwd_busy     (ffwd_busy),
        .ffwd_err      (ffwd_err),
        .dump_busy     (dump_busy)
    );
endmodule

// File: rtl/rx_pkt_buffer_chk.sv
module rx_pkt_buffer_chk #(
    parameter int DATA_DEPTH = 32,
    parameter int STAT_DEPTH = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        rx_halted,
    input logic                        host_data_rvalid,
    input logic                        host_stat_pop,
    input logic                        ffwd_busy,
    input logic                        ffwd_err,
    input logic                        dump_req,
    input logic                        dump_busy,
    input logic [$clog2(DATA_DEPTH):0] data_used,
    input logic [$clog2(STAT_DEPTH):0] stat_used
);
    // R5
    ffwd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ffwd_busy) |=> ffwd_busy);

    // R5
    ffwd_len_chk: assert property (@(posedge clk) disable iff (rst)
        (ffwd_busy && $past(ffwd_busy)) |=> !ffwd_busy);

    // R8
    ffwd_block_chk: assert property (@(posedge clk) disable iff (rst)
        ffwd_busy |-> !host_data_rvalid);

    // R7
    ffwd_err_chk: assert property (@(posedge clk) disable iff (rst)
        ffwd_err |-> !ffwd_busy);

    // R9
    ffwd_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (ffwd_busy && !host_stat_pop && !dump_busy) |=> (stat_used >= $past(stat_used)));

    // R11
    dump_clear_chk: assert property (@(posedge clk) disable iff (rst)
        dump_busy |=> (data_used == '0 && stat_used == '0 && !dump_busy));

    // R12
    dump_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (dump_req && !rx_halted && !dump_busy) |=> !dump_busy);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(data_used) <= DATA_DEPTH) && (int'(stat_used) <= STAT_DEPTH));
endmodule

bind rx_pkt_buffer rx_pkt_buffer_chk #(
    .DATA_DEPTH (DATA_DEPTH),
    .STAT_DEPTH (STAT_DEPTH)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .rx_halted        (rx_halted),
    .host_data_rvalid (host_data_rvalid),
    .host_stat_pop    (host_stat_pop),
    .ffwd_busy        (ffwd_busy),
    .ffwd_err         (ffwd_err),
    .dump_req         (dump_req),
    .dump_busy        (dump_busy),
    .data_used        (data_used),
    .stat_used        (stat_used)
);

// File: tb/rx_pkt_buffer_bench.sv
`timescale 1ns/1ps
module rx_pkt_buffer_bench;
    localparam int DD = 32;
    localparam int SD = 8;
    localparam int MP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [31:0] rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_halted = 1'b0;
    logic        host_data_pop = 1'b0;
    logic [31:0] host_data_rdata;
    logic        host_data_rvalid;
    logic        host_stat_pop = 1'b0;
    logic [31:0] host_stat_rdata;
    logic        host_stat_rvalid;
    logic        ffwd_req = 1'b0;
    logic        ffwd_busy;
    logic        ffwd_err;
    logic        dump_req = 1'b0;
    logic        dump_busy;
    logic [5:0]  data_used;
    logic [3:0]  stat_used;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    rx_pkt_buffer #(.DATA_DEPTH(DD), .STAT_DEPTH(SD), .MAX_PKT_WORDS(MP)) u_rx_pkt_buffer (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .rx_last(rx_last), .rx_halted(rx_halted),
        .host_data_pop(host_data_pop), .host_data_rdata(host_data_rdata),
        .host_data_rvalid(host_data_rvalid), .host_stat_pop(host_stat_pop),
        .host_stat_rdata(host_stat_rdata), .host_stat_rvalid(host_stat_rvalid),
        .ffwd_req(ffwd_req), .ffwd_busy(ffwd_busy), .ffwd_err(ffwd_err),
        .dump_req(dump_req), .dump_busy(dump_busy),
        .data_used(data_used), .stat_used(stat_used)
    );

    function automatic logic [31:0] wd(input int id, input int i);
        return 32'hA000_0000 + 32'(id) * 32'h100 + 32'(i);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_pkt(input int id, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = wd(id, i);
            rx_last  = (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    // called at a negedge; leaves at the following negedge
    task automatic pop_word(input string req, input logic [31:0] exp);
        check(req, host_data_rdata, exp);
        host_data_pop = 1'b1;
        @(negedge clk);
        host_data_pop = 1'b0;
    endtask

    task automatic pop_stat(input string req, input logic [31:0] exp);
        check(req, host_stat_rdata, exp);
        host_stat_pop = 1'b1;
        @(negedge clk);
        host_stat_pop = 1'b0;
    endtask

    task automatic do_dump();
        @(negedge clk);
        rx_halted = 1'b1;
        dump_req  = 1'b1;
        @(negedge clk);
        dump_req  = 1'b0;
        check("R11 dump busy", 32'(dump_busy), 32'd1);
        @(negedge clk);
        check("R11 data empty", 32'(data_used), 32'd0);
        check("R11 stat empty", 32'(stat_used), 32'd0);
        check("R11 dump done", 32'(dump_busy), 32'd0);
        rx_halted = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 data_used", 32'(data_used), 0);
        check("R1 stat_used", 32'(stat_used), 0);
        check("R1 rvalids", {30'd0, host_data_rvalid, host_stat_rvalid}, 0);
        check("R1 busy/err", {29'd0, ffwd_busy, dump_busy, ffwd_err}, 0);
        check("R1 rx_ready", 32'(rx_ready), 1);
    endtask

    task automatic t_write_read();
        push_pkt(1, 5);
        check("R2 data_used", 32'(data_used), 5);
        check("R2 stat_used", 32'(stat_used), 1);
        check("R2 stat word", host_stat_rdata, 32'd5);
        for (int i = 0; i < 5; i++) pop_word("R3 order", wd(1, i));
        check("R3 drained", 32'(data_used), 0);
        pop_stat("R3 stat", 32'd5);
        check("R3 stat drained", 32'(stat_used), 0);
    endtask

    task automatic t_admission();
        for (int p = 0; p < 3; p++) push_pkt(10 + p, 8);
        check("R4 ready with room", 32'(rx_ready), 1);
        push_pkt(13, 1);
        check("R4 data nearly full", 32'(rx_ready), 0);
        do_dump();
        for (int p = 0; p < 8; p++) push_pkt(20 + p, 1);
        check("R4 status full", 32'(rx_ready), 0);
        pop_stat("R4 stat pop", 32'd1);
        check("R4 slot held by data", 32'(rx_ready), 0);
        pop_word("R4 data pop", wd(20, 0));
        check("R4 slot freed", 32'(rx_ready), 1);
        do_dump();
    endtask

    task automatic t_ffwd();
        push_pkt(2, 6);
        push_pkt(3, 3);
        pop_word("R3 head A0", wd(2, 0));
        pop_word("R3 head A1", wd(2, 1));
        ffwd_req = 1'b1;
        @(negedge clk);
        ffwd_req = 1'b0;
        check("R5 busy c1", 32'(ffwd_busy), 1);
        check("R9 stat kept", 32'(stat_used), 2);
        check("R8 rvalid low", 32'(host_data_rvalid), 0);
        check("R9 stat head A", host_stat_rdata, 32'd6);
        host_data_pop = 1'b1;
        host_stat_pop = 1'b1;
        @(negedge clk);
        host_data_pop = 1'b0;
        host_stat_pop = 1'b0;
        check("R5 busy c2", 32'(ffwd_busy), 1);
        check("R8 data pop ignored", 32'(data_used), 7);
        check("R8 stat pop served", 32'(stat_used), 1);
        @(negedge clk);
        check("R5 busy clear", 32'(ffwd_busy), 0);
        check("R6 remaining skipped", 32'(data_used), 3);
        check("R5 next head", host_data_rdata, wd(3, 0));
        check("R9 stat head B", host_stat_rdata, 32'd3);
        for (int i = 0; i < 3; i++) pop_word("R3 B order", wd(3, i));
        pop_stat("R9 B stat", 32'd3);
    endtask

    task automatic t_ffwd_live();
        push_pkt(4, 5);
        ffwd_req = 1'b1;
        rx_valid = 1'b1; rx_data = wd(5, 0); rx_last = 1'b0;
        @(negedge clk);
        ffwd_req = 1'b0;
        rx_data = wd(5, 1); rx_last = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        @(negedge clk);
        check("R10 busy done", 32'(ffwd_busy), 0);
        check("R10 live words kept", 32'(data_used), 2);
        check("R10 head E0", host_data_rdata, wd(5, 0));
        check("R10 stat count", 32'(stat_used), 2);
        do_dump();
    endtask

    task automatic t_short();
        @(negedge clk);
        ffwd_req = 1'b1;
        @(negedge clk);
        ffwd_req = 1'b0;
        check("R7 empty err", 32'(ffwd_err), 1);
        push_pkt(6, 3);
        ffwd_req = 1'b1;
        @(negedge clk);
        ffwd_req = 1'b0;
        check("R7 short err", 32'(ffwd_err), 1);
        check("R7 no busy", 32'(ffwd_busy), 0);
        @(negedge clk);
        check("R7 err pulse", 32'(ffwd_err), 0);
        check("R7 data kept", 32'(data_used), 3);
        check("R7 head kept", host_data_rdata, wd(6, 0));
        do_dump();
    endtask

    task automatic t_dump_gate();
        push_pkt(7, 4);
        dump_req = 1'b1;
        @(negedge clk);
        dump_req = 1'b0;
        check("R12 no busy", 32'(dump_busy), 0);
        @(negedge clk);
        check("R12 data kept", 32'(data_used), 4);
        check("R12 stat kept", 32'(stat_used), 1);
        do_dump();
        check("R11 ready after", 32'(rx_ready), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_admission();
        t_ffwd();
        t_ffwd_live();
        t_short();
        t_dump_gate();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule